// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two dependent entries from a translation structure in memory. The virtual address is cut into three parts. The top ten bits index a first-level table, called the directory. The next ten bits index a second-level table. The low twelve bits pass through unchanged as the byte offset. The directory starts at a page-aligned physical address that software loads into a base register.

A walk starts when a request is accepted while the walker is idle. The walker reads the directory entry. If that entry is present, it reads the table entry that the directory entry points to. It then reports either the physical address or a fault that names the level which stopped the walk. Memory is reached through a one-cycle read strobe with a byte address. The read data returns on a valid signal after any number of cycles.

Top module: `ptw_top`

## Requirements
- R1: After reset, `reqReady` is 1, and `done`, `fault` and `memReqValid` are 0.
- R2: The first read of a walk uses byte address `{base[31:12], 12'h000} + vaddr[31:22]*4`. Every read address is a multiple of 4.
- R3: The second read uses byte address `{dirEntry[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: On success, `paddr` is `{tblEntry[31:12], vaddr[11:0]}` and `fault` is 0. Example: vaddr 0x13A49F01 with frame 0x0341B000 gives 0x0341BF01.
- R5: If bit 0 (present) of the directory entry is 0, the walk ends after one read with `fault`=1 and `faultLevel`=0.
- R6: If bit 0 (present) of the table entry is 0, the walk ends after two reads with `fault`=1 and `faultLevel`=1.
- R7: `done` is high for exactly one cycle per walk. A request is accepted only while `reqReady` is 1. A `reqValid` raised during a walk starts nothing and does not change that walk's result.
- R8: A base write that arrives while a walk is in progress has no effect. Later walks still use the previous base.
- R9: The low 12 bits of a base write are discarded, so the directory is always page-aligned.
- R10: The walker waits any number of cycles for `memRspValid`. The result does not depend on the response latency.
- R11: Each read strobe `memReqValid` lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Load the directory base register (accepted only when idle) |
| baseWrData | input | 32 | New directory base; bits 11..0 are discarded |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker is idle and will accept a request |
| memReqValid | output | 1 | One-cycle read strobe |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse when the walk ends |
| paddr | output | 32 | Translated physical address |
| fault | output | 1 | Walk ended on an entry that is not present |
| faultLevel | output | 1 | 0 = directory entry, 1 = table entry |

## Verification
The assertions check four properties on every cycle: `done` and the read strobe are single-cycle pulses, every read address is word-aligned, an accepted request leads straight to a read, and the base register holds steady while a walk is busy. On a successful walk they also check that the offset of `paddr` matches the offset of the virtual address. Some behaviours depend on memory contents and on timing, and only the bench scenarios show them. These are the exact addresses of both reads, the early stop after a missing directory entry, the reporting of the fault level, independence from response latency, and the dropping of base writes and requests that arrive mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_DIR, ST_WAIT_DIR, ST_READ_PT, ST_WAIT_PT, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic baseLoad;   // accept base write
    logic reqLatch;   // capture virtual address, clear result
    logic tblLatch;   // capture table base from directory entry
    logic selTable;   // address mux: 0 directory, 1 table
    logic okFinish;   // write translated address
    logic dirFault;   // record directory-level fault
    logic tblFault;   // record table-level fault
  } walkCtrl_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      baseWrEn,
  input  logic      reqValid,
  input  logic      memRspValid,
  input  logic      presentBit,
  output walkCtrl_t ctrl,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      done,
  output logic      busy
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        ctrl.baseLoad = baseWrEn;
        if (reqValid) begin
          ctrl.reqLatch = 1'b1;
          stateD = ST_READ_DIR;
        end
      end
      ST_READ_DIR: stateD = ST_WAIT_DIR;
      ST_WAIT_DIR: if (memRspValid) begin
        if (presentBit) begin
          ctrl.tblLatch = 1'b1;
          stateD = ST_READ_PT;
        end else begin
          ctrl.dirFault = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_READ_PT: begin
        ctrl.selTable = 1'b1;
        stateD = ST_WAIT_PT;
      end
      ST_WAIT_PT: if (memRspValid) begin
        if (presentBit) ctrl.okFinish = 1'b1;
        else            ctrl.tblFault = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_READ_DIR) || (stateQ == ST_READ_PT);
  assign done        = (stateQ == ST_DONE);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_accept_reads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memReqValid);
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 10,
  parameter int TBL_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_SH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtrl_t         ctrl,
  input  logic              busy,
  input  logic              done,
  input  logic              memReqValid,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault,
  output logic              faultLevel
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [FRAME_W-1:0] baseQ, tblBaseQ;
  logic [ADDR_W-1:0]  vaddrQ;
  logic [DIR_W-1:0]   dirIdx;
  logic [TBL_W-1:0]   tblIdx;
  logic [ADDR_W-1:0]  dirAddr, tblAddr;

  assign dirIdx  = vaddrQ[ADDR_W-1 -: DIR_W];
  assign tblIdx  = vaddrQ[OFF_W +: TBL_W];
  assign dirAddr = {baseQ, {OFF_W{1'b0}}} + (ADDR_W'(dirIdx) << ENT_SH);
  assign tblAddr = {tblBaseQ, {OFF_W{1'b0}}} + (ADDR_W'(tblIdx) << ENT_SH);
  assign memReqAddr = ctrl.selTable ? tblAddr : dirAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      tblBaseQ   <= '0;
      vaddrQ     <= '0;
      paddr      <= '0;
      fault      <= 1'b0;
      faultLevel <= 1'b0;
    end else begin
      if (ctrl.baseLoad) baseQ <= baseWrData[ADDR_W-1:OFF_W];
      if (ctrl.reqLatch) begin
        vaddrQ     <= reqVaddr;
        paddr      <= '0;
        fault      <= 1'b0;
        faultLevel <= 1'b0;
      end
      if (ctrl.tblLatch) tblBaseQ <= memRspData[ADDR_W-1:OFF_W];
      if (ctrl.okFinish) paddr <= {memRspData[ADDR_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
      if (ctrl.dirFault) begin
        fault      <= 1'b1;
        faultLevel <= 1'b0;
      end
      if (ctrl.tblFault) begin
        fault      <= 1'b1;
        faultLevel <= 1'b1;
      end
    end
  end

  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(baseQ));
  p_word_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[ENT_SH-1:0] == '0));
  p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (paddr[OFF_W-1:0] == vaddrQ[OFF_W-1:0]));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 10,
  parameter int TBL_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic              reqReady,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              done,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault,
  output logic              faultLevel
);
  localparam int ENT_SH = 2;

  walkCtrl_t ctrl;
  logic      busy;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .reqValid(reqValid),
    .memRspValid(memRspValid), .presentBit(memRspData[0]), .ctrl(ctrl),
    .reqReady(reqReady), .memReqValid(memReqValid), .done(done), .busy(busy)
  );

  ptw_dpath #(
    .ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W), .ENT_SH(ENT_SH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busy(busy), .done(done),
    .memReqValid(memReqValid), .baseWrData(baseWrData), .reqVaddr(reqVaddr),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .paddr(paddr),
    .fault(fault), .faultLevel(faultLevel)
  );
endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, memReqValid, done, fault, faultLevel;
  logic [31:0] memReqAddr, paddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  ptw_top dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int latency = 0;
  int nReads = 0;
  logic [31:0] rdAddr [0:3];
  logic [31:0] mem [logic [31:0]];
  bit pending = 0;
  int dly = 0;
  logic [31:0] pendAddr = '0;

  // memory model: answers each strobe after `latency` extra cycles
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pending) begin
      if (dly == 0) begin
        memRspValid = 1'b1;
        memRspData  = mem.exists(pendAddr >> 2) ? mem[pendAddr >> 2] : 32'h0;
        pending = 0;
      end else dly--;
    end
    if (memReqValid && rstN) begin
      pending  = 1;
      pendAddr = memReqAddr;
      dly      = latency;
      if (nReads < 4) rdAddr[nReads] = memReqAddr;
      nReads++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk); baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk); baseWrEn = 1'b0;
  endtask

  // launch a walk; optionally poke base/request mid-walk; wait for done
  task automatic walk(input logic [31:0] va, input bit poke);
    bit seen = 0;
    nReads = 0;
    @(negedge clk); reqValid = 1'b1; reqVaddr = va;
    @(negedge clk); reqValid = 1'b0;
    if (poke) begin
      @(negedge clk);
      check("R7 ready low while busy", {31'b0, reqReady}, 32'd0);
      baseWrEn = 1'b1; baseWrData = 32'h7777_7000;
      reqValid = 1'b1; reqVaddr = 32'h0000_0000;
      @(negedge clk); baseWrEn = 1'b0; reqValid = 1'b0;
    end
    for (int i = 0; i < 100 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check("R7 done seen", {31'b0, seen}, 32'd1);
  endtask

  typedef struct packed {
    logic [31:0] va, dirE, tblE, expPa;
    logic        expFault, expLvl;
    logic [2:0]  expReads;
  } vec_t;

  localparam logic [31:0] BASE = 32'h0001_C000;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h13A4_9F01, 32'h000A_2001, 32'h0341_B001, 32'h0341_BF01, 1'b0, 1'b0, 3'd2},
    '{32'h0000_0000, 32'h0000_5001, 32'h1234_5001, 32'h1234_5000, 1'b0, 1'b0, 3'd2},
    '{32'hFFFF_FFFF, 32'h7FFF_F001, 32'hABCD_E003, 32'hABCD_EFFF, 1'b0, 1'b0, 3'd2},
    '{32'h0040_0123, 32'h0001_0000, 32'h5555_5001, 32'h0000_0000, 1'b1, 1'b0, 3'd1},
    '{32'h8000_1ABC, 32'h0002_0001, 32'h9999_9000, 32'h0000_0000, 1'b1, 1'b1, 3'd2}
  };

  function automatic logic [31:0] dirA(input logic [31:0] b, input logic [31:0] va);
    return {b[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] tblA(input logic [31:0] de, input logic [31:0] va);
    return {de[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic runVec(input vec_t v, input logic [31:0] b, input bit poke);
    mem[dirA(b, v.va) >> 2] = v.dirE;
    mem[tblA(v.dirE, v.va) >> 2] = v.tblE;
    walk(v.va, poke);
    check("R4 paddr", paddr, v.expPa);
    check(v.expLvl ? "R6 fault" : "R5 fault", {31'b0, fault}, {31'b0, v.expFault});
    if (v.expFault) check("R5/R6 level", {31'b0, faultLevel}, {31'b0, v.expLvl});
    check("R5 read count", nReads, {29'b0, v.expReads});
    check("R2 dir addr", rdAddr[0], dirA(b, v.va));
    if (v.expReads == 2) check("R3 table addr", rdAddr[1], tblA(v.dirE, v.va));
    @(negedge clk);
    check("R7 done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", {31'b0, reqReady}, 32'd1);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 fault", {31'b0, fault}, 32'd0);
    check("R1 memReqValid", {31'b0, memReqValid}, 32'd0);
    rstN = 1'b1;
    setBase(BASE);
    for (int i = 0; i < NV; i++) runVec(VECS[i], BASE, 0);
    // R10: slow memory
    latency = 3;
    for (int i = 0; i < NV; i++) runVec(VECS[i], BASE, 0);
    latency = 0;
    // R8 and R7: base write and request during a walk are dropped
    runVec(VECS[0], BASE, 1);
    runVec(VECS[1], BASE, 0);
    // R9: low bits of base discarded
    setBase(32'h1234_5ABC);
    runVec(VECS[2], 32'h1234_5000, 0);
    check("R9 base aligned", rdAddr[0], 32'h1234_5000 + 32'hFFC);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule